// File: doc/BRIEF.md
# ROM Prefetch Read Buffer

This block holds one byte read ahead from ROM for a coprocessor. Writing the ROM pointer register starts a fetch in the background. The fetch waits out a memory latency countdown that comes from the clock speed divider. When the countdown expires, the block reads the ROM once, at the address formed from the bank register and the pointer, and keeps that byte in a data latch.

A consumer may ask for the byte at any time. It is held off by a combinational stall only while the fetch is still counting down. After the stall drops, the latch holds the newly fetched byte.

A synchronous timing clear drops any pending fetch and zeroes the data latch. The ROM itself is outside the block. It is driven through a one-cycle read strobe, and its data is expected to be valid in that same cycle.

Top module: `rom_prefetch_buf`

## Requirements
- R1: After reset, `busy`, `stall` and `rom_re` are low and `dout` is 0, even if `rd_req` is high.
- R2: A clock edge with `ptr_we` high, and `tmg_clr` low, loads the pointer from `ptr_wdata` and starts a fetch. `busy` is high from the next cycle on.
- R3: A fetch keeps `busy` high for exactly `div` + 4 cycles. That is 5 cycles with divider 1, 6 cycles with divider 2, and 4 and 7 cycles with divider 0 and 3.
- R4: In the last busy cycle of a fetch, `rom_re` is high for that one cycle only. In that cycle `rom_addr` is `{bank, pointer}`, with the bank in bits 23:16, and the bank value is the one present in that cycle.
- R5: At the edge that ends that cycle, `dout` takes `rom_rdata` and `busy` falls. At every other edge `dout` keeps its value.
- R6: The countdown stops at zero and never wraps. While idle and without writes, `busy` stays low and no further `rom_re` pulse occurs.
- R7: `stall` equals `rd_req` AND `busy`, with no clock delay. A consumer that holds `rd_req` from the start of a fetch is stalled for exactly the fetch latency, and then sees the new byte on `dout`.
- R8: A pointer write during a pending fetch restarts the full latency and redirects the fetch to the new pointer. The abandoned address is never strobed, so only one `rom_re` pulse occurs.
- R9: A clock edge with `tmg_clr` high makes `busy` low and `dout` 0. It cancels the pending fetch, so no strobe follows. A pointer write at the same edge is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tmg_clr | input | 1 | Synchronous timing clear, has priority over a pointer write |
| ptr_we | input | 1 | Pointer register write strobe |
| ptr_wdata | input | 16 | New pointer value |
| bank | input | 8 | ROM bank register value |
| div | input | 2 | Clock speed divider value |
| rd_req | input | 1 | Consumer read request |
| rom_rdata | input | 8 | ROM read data, valid in the cycle of `rom_re` |
| rom_re | output | 1 | One-cycle ROM read strobe at countdown expiry |
| rom_addr | output | 24 | ROM address `{bank, pointer}` |
| dout | output | 8 | Latched prefetched byte |
| busy | output | 1 | Fetch pending |
| stall | output | 1 | Consumer must wait |

## Verification
The assertions assume that the ROM returns its data in the same cycle as the strobe. They also assume that `div` stays steady while a countdown is loaded, because the latency is taken from `div` at the write edge.

The bench drives every input half a cycle away from the active edge. It changes `div` only while the block is idle. It moves `bank` in the middle of a fetch only to show that the bank is read late. Its ROM is a combinational function of the address, so each captured byte identifies the address that produced it.

// File: rtl/rom_prefetch_buf.sv
module rom_prefetch_buf #(
  parameter int PTR_W   = 16,
  parameter int BANK_W  = 8,
  parameter int DATA_W  = 8,
  parameter int DIV_W   = 2,
  parameter int LAT_ADD = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    tmg_clr,
  input  logic                    ptr_we,
  input  logic [PTR_W-1:0]        ptr_wdata,
  input  logic [BANK_W-1:0]       bank,
  input  logic [DIV_W-1:0]        div,
  input  logic                    rd_req,
  input  logic [DATA_W-1:0]       rom_rdata,
  output logic                    rom_re,
  output logic [BANK_W+PTR_W-1:0] rom_addr,
  output logic [DATA_W-1:0]       dout,
  output logic                    busy,
  output logic                    stall
);
  localparam int CNT_MAX = (1 << DIV_W) - 1 + LAT_ADD;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  logic [CNT_W-1:0] cnt;
  logic [PTR_W-1:0] ptr;
  logic             load;
  logic             expire;

  assign load     = ptr_we && !tmg_clr;
  assign expire   = (cnt == CNT_W'(1)) && !load && !tmg_clr;
  assign busy     = (cnt != '0);
  assign stall    = rd_req && busy;
  assign rom_re   = expire;
  assign rom_addr = {bank, ptr};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      ptr  <= '0;
      dout <= '0;
    end else if (tmg_clr) begin
      cnt  <= '0;
      dout <= '0;
    end else if (load) begin
      ptr <= ptr_wdata;
      cnt <= CNT_W'(div) + CNT_W'(LAT_ADD);
    end else if (busy) begin
      cnt <= cnt - CNT_W'(1);
      if (expire) dout <= rom_rdata;
    end
  end

  AST_LOAD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> busy);  // R2
  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !ptr_we |=> !busy);  // R6
  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rom_re && !ptr_we |=> !rom_re && !busy);  // R4
  AST_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    rom_re |=> dout == $past(rom_rdata));  // R5
  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rom_re && !tmg_clr |=> $stable(dout));  // R5
  AST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    tmg_clr |=> !busy && dout == '0);  // R9
  AST_STALL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !stall);  // R7
endmodule

// File: tb/rom_prefetch_buf_tb.sv
module rom_prefetch_buf_tb_top;
  localparam int CLK_P = 10;

  logic        clk = 0, rst_n = 0, tmg_clr = 0, ptr_we = 0, rd_req = 0;
  logic [15:0] ptr_wdata = '0;
  logic [7:0]  bank = '0;
  logic [1:0]  div = 2'd1;
  logic [7:0]  rom_rdata, dout;
  logic [23:0] rom_addr;
  logic        rom_re, busy, stall;

  int checks = 0, fails = 0;
  int re_cnt = 0;
  logic [23:0] re_addr = '0;

  always #(CLK_P/2) clk = ~clk;

  function automatic logic [7:0] rom_f(input logic [23:0] a);
    return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'hA5;
  endfunction
  assign rom_rdata = rom_f(rom_addr);

  rom_prefetch_buf dut_i (.clk, .rst_n, .tmg_clr, .ptr_we, .ptr_wdata, .bank, .div,
    .rd_req, .rom_rdata, .rom_re, .rom_addr, .dout, .busy, .stall);

  always begin
    @(negedge clk); #(CLK_P/4);
    if (rom_re) begin re_cnt++; re_addr = rom_addr; end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin fails++; $display("FAIL %s actual=%0h expected=%0h", tag, act, exp); end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  task automatic write_ptr(input logic [15:0] p);
    @(negedge clk); ptr_we = 1; ptr_wdata = p;
    @(negedge clk); ptr_we = 0;
  endtask

  task automatic wait_busy(output int n);
    n = 0;
    while (busy && n < 50) begin n++; @(negedge clk); end
    #1;
  endtask

  task automatic t_reset();
    rd_req = 1; #1;
    chk(busy == 0, "R1 busy", busy, 0);
    chk(stall == 0, "R1 stall", stall, 0);
    chk(dout == 0, "R1 dout", dout, 0);
    chk(rom_re == 0, "R1 rom_re", rom_re, 0);
    rd_req = 0;
  endtask

  task automatic t_fetch(input logic [1:0] d, input logic [15:0] p, input logic [7:0] b);
    int n;
    logic [23:0] a;
    @(negedge clk); div = d; bank = b;
    re_cnt = 0;
    write_ptr(p); #1;
    chk(busy == 1, "R2 busy after write", busy, 1);
    wait_busy(n);
    a = {b, p};
    chk(n == int'(d) + 4, "R3 latency", n, int'(d) + 4);
    chk(re_cnt == 1, "R4 strobe count", re_cnt, 1);
    chk(re_addr == a, "R4 address", re_addr, a);
    chk(dout == rom_f(a), "R5 captured byte", dout, rom_f(a));
  endtask

  task automatic t_idle();
    logic [7:0] d0;
    d0 = dout; re_cnt = 0;
    repeat (12) @(negedge clk);
    #1;
    chk(busy == 0, "R6 stays idle", busy, 0);
    chk(re_cnt == 0, "R6 no strobe", re_cnt, 0);
    chk(dout == d0, "R5 dout held", dout, d0);
  endtask

  task automatic t_stall();
    int n;
    @(negedge clk); div = 2'd2; bank = 8'h3C; re_cnt = 0;
    @(negedge clk); ptr_we = 1; ptr_wdata = 16'h1234;
    @(negedge clk); ptr_we = 0; #1;
    chk(stall == 0, "R7 no stall without request", stall, 0);
    rd_req = 1; #1;
    n = 0;
    while (stall && n < 50) begin n++; @(negedge clk); #1; end
    chk(n == 6, "R7 stall cycles", n, 6);
    chk(dout == rom_f(24'h3C1234), "R7 new byte after stall", dout, rom_f(24'h3C1234));
    rd_req = 0;
  endtask

  task automatic t_restart();
    int n;
    @(negedge clk); div = 2'd1; bank = 8'h11; re_cnt = 0;
    write_ptr(16'hAAAA);
    @(negedge clk);
    write_ptr(16'h5555);
    wait_busy(n);
    chk(n == 5, "R8 restarted latency", n, 5);
    chk(re_cnt == 1, "R8 single strobe", re_cnt, 1);
    chk(re_addr == 24'h115555, "R8 redirected address", re_addr, 24'h115555);
  endtask

  task automatic t_bank_late();
    int n;
    @(negedge clk); div = 2'd1; bank = 8'h01; re_cnt = 0;
    write_ptr(16'h0F0F);
    @(negedge clk); bank = 8'hE7;
    wait_busy(n);
    chk(re_addr == 24'hE70F0F, "R4 bank sampled at expiry", re_addr, 24'hE70F0F);
    chk(dout == rom_f(24'hE70F0F), "R5 byte from late bank", dout, rom_f(24'hE70F0F));
  endtask

  task automatic t_clear();
    @(negedge clk); div = 2'd3; bank = 8'h22; re_cnt = 0;
    write_ptr(16'h7777);
    @(negedge clk); tmg_clr = 1; ptr_we = 1; ptr_wdata = 16'h9999;
    @(negedge clk); tmg_clr = 0; ptr_we = 0; #1;
    chk(busy == 0, "R9 busy cleared", busy, 0);
    chk(dout == 0, "R9 dout cleared", dout, 0);
    repeat (10) @(negedge clk);
    #1;
    chk(re_cnt == 0, "R9 fetch cancelled", re_cnt, 0);
    chk(busy == 0, "R9 write ignored", busy, 0);
  endtask

  initial begin
    #(CLK_P * 100000);
    chk(0, "watchdog", 0, 1);
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_fetch(2'd1, 16'hBEEF, 8'h40);
    t_fetch(2'd2, 16'h0102, 8'h7F);
    t_fetch(2'd0, 16'hFFFF, 8'hFF);
    t_fetch(2'd3, 16'h0000, 8'h00);
    t_idle();
    t_stall();
    t_restart();
    t_bank_late();
    t_clear();
    report();
  end
endmodule